// File: doc/BRIEF.md
# Time-Shift Audio Buffer Controller

This block sits between an audio sampler and a playback converter and gives a listener a rewind control over live audio. Every incoming 12-bit sample is written into a circular sample memory, and recording never stops. A separate read position decides what is played back. Pause, play, a short rewind tap, a long rewind hold, jump-to-live and jump-to-begin move only that read position.

The sample memory sits outside the block. The block drives a 16-bit write port and a read port with one cycle of read latency, and takes the read word back on `memRdata`. The buffer holds `2**ADDR_W` samples. For ten minutes of history at the full 50 kHz rate, `ADDR_W` must be at least 25. `JUMP_LEN` is the rewind step in samples; 15 seconds is 750000. `HOLD_CYCLES` is the clock count that tells a tap from a hold; 3 seconds is the clock rate times three. The defaults are scaled down so the block can be checked quickly.

Positions are tracked as an age: the number of samples between the read position and the newest stored sample. Age 0 is live mode. Live playback lags the input by one sample period, well under one second. The oldest held sample sits at address 0 until the write address first wraps. After that it is the address about to be overwritten.

Top module: `time_shift_buffer`

## Requirements
- R1: Every `inStb` cycle writes one word at the current write address, whatever the playback mode. The word holds the sample in bits 11:0 and zeros in bits 15:12. The write address then advances by one and wraps modulo `2**ADDR_W`.
- R2: While playing (not paused, not reversing), each `inStb` cycle produces one `outStb` pulse, visible after the second rising edge that follows the strobe. That pulse carries the sample at the read position, and the read position then advances by one. In live mode the sample played is the newest one written before that strobe. A strobe on an empty buffer plays the value zero.
- R3: While paused, no `outStb` is produced. After play, output resumes with the very sample that would have been played next.
- R4: If a pause lasts long enough for the writes to overwrite the paused position, the read position is pulled forward to the oldest sample still held.
- R5: A rewind press released after fewer than `HOLD_CYCLES` clock cycles moves the read position back by `JUMP_LEN` samples, exactly once per press. It stops at the oldest held sample and leaves the pause state unchanged.
- R6: A rewind press held for more than `HOLD_CYCLES` cycles enters reverse. Each strobe then plays the sample at the read position and steps one sample older, never past the oldest held sample. Release ends reverse with no jump and restores the earlier pause state.
- R7: A rising edge of `btnLive` sets the age to 0 and clears pause.
- R8: A rising edge of `btnBegin` moves the read position to the oldest held sample and keeps the pause state.
- R9: When several button events fall in the same cycle, only the highest one acts, in this order: live, begin, rewind release, pause, play. While reversing, live, begin, pause and play edges are ignored.
- R10: A button edge or rewind release that coincides with an `inStb` cycle takes effect in the next cycle without a strobe. The sample of that strobe is handled in the old mode.
- R11: `ledPause` is high only while paused and not reversing. `ledLive` is high only while playing at age 0. `ledPower` is high from the first clock after reset onward.
- R12: After reset the buffer is empty, playback is unpaused at age 0 (so `ledLive` is high), `outSample` is zero and `outStb` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inSample | input | 12 | Incoming audio sample |
| inStb | input | 1 | One-cycle strobe marking a new sample |
| btnRewind | input | 1 | Debounced rewind button level |
| btnPlay | input | 1 | Debounced play button level |
| btnPause | input | 1 | Debounced pause button level |
| btnLive | input | 1 | Debounced jump-to-live button level |
| btnBegin | input | 1 | Debounced jump-to-oldest button level |
| memWe | output | 1 | Sample memory write enable |
| memWaddr | output | ADDR_W | Sample memory write address |
| memWdata | output | 16 | Sample memory write word |
| memRe | output | 1 | Sample memory read enable |
| memRaddr | output | ADDR_W | Sample memory read address |
| memRdata | input | 16 | Read word, valid one cycle after memRe |
| outSample | output | 12 | Playback sample |
| outStb | output | 1 | One-cycle strobe marking a playback sample |
| ledPause | output | 1 | Pause indicator |
| ledLive | output | 1 | Live-mode indicator |
| ledPower | output | 1 | Power indicator |

## Verification
The bench targets the points where the oldest-sample boundary moves.

- A pause that outlasts the buffer must come back at the oldest surviving sample. A design that does not pull the position forward would replay overwritten data from one lap later.
- A reverse run longer than the buffer must stop at the oldest sample even though that sample advances on every strobe. A design that clamps against the old boundary would play a freshly written sample as if it were ancient.
- The first strobe after reset must play zero, not the unwritten memory word.
- A pause edge that lands on a strobe must still let that strobe's sample out.
- Simultaneous buttons must follow the stated priority. Pause pressed during reverse must have no effect after release.

// File: rtl/tsb_pkg.sv
package tsb_pkg;

  // How the read position is updated in a given cycle
  typedef enum logic [2:0] {
    AGE_KEEP,     // read position unchanged
    AGE_LIVE,     // age forced to zero (newest sample)
    AGE_BEGIN,    // age forced to the oldest held sample
    AGE_REWIND,   // age grows by the jump length, clamped
    AGE_PLAY,     // forward step while the write pointer also steps
    AGE_HOLD,     // paused strobe: keep sample, clamp if overwritten
    AGE_REVERSE   // reverse strobe: one sample older, clamped
  } ageOp_e;

  typedef struct packed {
    logic   wrStb;  // store the incoming sample
    logic   emit;   // play one sample for this strobe
    ageOp_e ageOp;  // read position update
  } ctlStrb_t;

endpackage

// File: rtl/tsb_hold_timer.sv
module tsb_hold_timer #(
  parameter int HOLD_CYCLES = 40
) (
  input  logic clk,
  input  logic rstN,
  input  logic held,
  output logic longHold
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HOLD_CYCLES);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               holdCnt <= '0;
    else if (!held)          holdCnt <= '0;
    else if (holdCnt != LIMIT) holdCnt <= holdCnt + ONE;
  end

  assign longHold = (holdCnt == LIMIT);
endmodule

// File: rtl/tsb_ctrl.sv
module tsb_ctrl
  import tsb_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inStb,
  input  logic     btnRewind,
  input  logic     btnPlay,
  input  logic     btnPause,
  input  logic     btnLive,
  input  logic     btnBegin,
  input  logic     longHold,
  input  logic     atNewest,
  output ctlStrb_t ctl,
  output logic     ledPause,
  output logic     ledLive,
  output logic     ledPower
);
  logic paused, reversing, powerOn;
  logic prevRew, prevPlay, prevPause, prevLive, prevBegin;
  logic liveEdge, beginEdge, pauseEdge, playEdge, rewRelease;

  // Edges are only consumed in strobe-free cycles; otherwise they wait
  assign liveEdge   = btnLive   & ~prevLive   & ~inStb;
  assign beginEdge  = btnBegin  & ~prevBegin  & ~inStb;
  assign pauseEdge  = btnPause  & ~prevPause  & ~inStb;
  assign playEdge   = btnPlay   & ~prevPlay   & ~inStb;
  assign rewRelease = ~btnRewind & prevRew    & ~inStb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevRew   <= 1'b0;
      prevPlay  <= 1'b0;
      prevPause <= 1'b0;
      prevLive  <= 1'b0;
      prevBegin <= 1'b0;
    end else if (!inStb) begin
      prevRew   <= btnRewind;
      prevPlay  <= btnPlay;
      prevPause <= btnPause;
      prevLive  <= btnLive;
      prevBegin <= btnBegin;
    end
  end

  always_comb begin
    ctl.wrStb = inStb;
    ctl.emit  = inStb & (~paused | reversing);
    ctl.ageOp = AGE_KEEP;
    if (inStb) begin
      if (reversing)   ctl.ageOp = AGE_REVERSE;
      else if (paused) ctl.ageOp = AGE_HOLD;
      else             ctl.ageOp = AGE_PLAY;
    end else if (!reversing) begin
      if (liveEdge)        ctl.ageOp = AGE_LIVE;
      else if (beginEdge)  ctl.ageOp = AGE_BEGIN;
      else if (rewRelease) ctl.ageOp = AGE_REWIND;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      paused    <= 1'b0;
      reversing <= 1'b0;
      powerOn   <= 1'b0;
    end else begin
      powerOn <= 1'b1;
      if (reversing) begin
        if (rewRelease) reversing <= 1'b0;
      end else begin
        if (longHold && btnRewind) reversing <= 1'b1;
        if (liveEdge)                      paused <= 1'b0;
        else if (beginEdge || rewRelease)  paused <= paused;
        else if (pauseEdge)                paused <= 1'b1;
        else if (playEdge)                 paused <= 1'b0;
      end
    end
  end

  assign ledPause = paused & ~reversing;
  assign ledLive  = ~paused & ~reversing & atNewest;
  assign ledPower = powerOn;
endmodule

// File: rtl/tsb_datapath.sv
module tsb_datapath
  import tsb_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int SAMPLE_W = 12,
  parameter int WORD_W   = 16,
  parameter int JUMP_LEN = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrb_t            ctl,
  input  logic [SAMPLE_W-1:0] inSample,
  input  logic [WORD_W-1:0]   memRdata,
  output logic                memWe,
  output logic [ADDR_W-1:0]   memWaddr,
  output logic [WORD_W-1:0]   memWdata,
  output logic                memRe,
  output logic [ADDR_W-1:0]   memRaddr,
  output logic [SAMPLE_W-1:0] outSample,
  output logic                outStb,
  output logic                atNewest
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int AGE_W = ADDR_W + 2;
  localparam logic [ADDR_W-1:0] ONE_A   = ADDR_W'(1);
  localparam logic [AGE_W-1:0]  ONE_G   = AGE_W'(1);
  localparam logic [AGE_W-1:0]  TWO_G   = AGE_W'(2);
  localparam logic [AGE_W-1:0]  DEPTH_G = AGE_W'(DEPTH);
  localparam logic [AGE_W-1:0]  JUMP_G  = AGE_W'(JUMP_LEN);

  logic [ADDR_W-1:0] wrPtr, rdPtr, wrNext, ageRaw, base, rdNext;
  logic              full, fullNext, empty, readPend, zeroPend;
  logic [AGE_W-1:0]  agePre, countCur, countNext, limCur, limPost, ageSel;
  logic [WORD_W-SAMPLE_W-1:0] unusedRdHi;
  logic [AGE_W-ADDR_W-1:0]    unusedAgeHi;

  function automatic logic [AGE_W-1:0] minAge(input logic [AGE_W-1:0] a,
                                               input logic [AGE_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  always_comb begin
    empty     = ~full & (wrPtr == '0);
    wrNext    = wrPtr + ONE_A;
    fullNext  = full | (wrPtr == '1);
    countCur  = full ? DEPTH_G : {2'b00, wrPtr};
    countNext = fullNext ? DEPTH_G : {2'b00, wrNext};
    limCur    = empty ? '0 : countCur - ONE_G;
    limPost   = countNext - ONE_G;
    ageRaw    = wrPtr - rdPtr - ONE_A;
    agePre    = {2'b00, ageRaw};
    base      = wrPtr;
    ageSel    = '0;
    case (ctl.ageOp)
      AGE_LIVE:    ageSel = '0;
      AGE_BEGIN:   ageSel = limCur;
      AGE_REWIND:  ageSel = minAge(agePre + JUMP_G, limCur);
      AGE_HOLD: begin
        base   = wrNext;
        ageSel = minAge(agePre + ONE_G, limPost);
      end
      AGE_REVERSE: begin
        base   = wrNext;
        ageSel = minAge(agePre + TWO_G, limPost);
      end
      default:     ageSel = '0;
    endcase
    case (ctl.ageOp)
      AGE_KEEP: rdNext = rdPtr;
      AGE_PLAY: rdNext = rdPtr + ONE_A;
      default:  rdNext = base - ONE_A - ageSel[ADDR_W-1:0];
    endcase
  end

  assign unusedRdHi  = memRdata[WORD_W-1:SAMPLE_W];
  assign unusedAgeHi = ageSel[AGE_W-1:ADDR_W];

  assign memWe    = ctl.wrStb;
  assign memWaddr = wrPtr;
  assign memWdata = WORD_W'(inSample);
  assign memRe    = ctl.emit & ~empty;
  assign memRaddr = rdPtr;
  assign atNewest = (rdPtr + ONE_A) == wrPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      full      <= 1'b0;
      rdPtr     <= '1;
      readPend  <= 1'b0;
      zeroPend  <= 1'b0;
      outStb    <= 1'b0;
      outSample <= '0;
    end else begin
      if (ctl.wrStb) begin
        wrPtr <= wrNext;
        full  <= fullNext;
      end
      rdPtr    <= rdNext;
      readPend <= memRe;
      zeroPend <= ctl.emit & empty;
      outStb   <= readPend | zeroPend;
      if (readPend)      outSample <= memRdata[SAMPLE_W-1:0];
      else if (zeroPend) outSample <= '0;
    end
  end
endmodule

// File: rtl/time_shift_buffer.sv
module time_shift_buffer
  import tsb_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int JUMP_LEN    = 10,
  parameter int HOLD_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [11:0]       inSample,
  input  logic              inStb,
  input  logic              btnRewind,
  input  logic              btnPlay,
  input  logic              btnPause,
  input  logic              btnLive,
  input  logic              btnBegin,
  output logic              memWe,
  output logic [ADDR_W-1:0] memWaddr,
  output logic [15:0]       memWdata,
  output logic              memRe,
  output logic [ADDR_W-1:0] memRaddr,
  input  logic [15:0]       memRdata,
  output logic [11:0]       outSample,
  output logic              outStb,
  output logic              ledPause,
  output logic              ledLive,
  output logic              ledPower
);
  ctlStrb_t ctl;
  logic     longHold, atNewest;

  tsb_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) hold_i (
    .clk(clk), .rstN(rstN), .held(btnRewind), .longHold(longHold)
  );

  tsb_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inStb(inStb),
    .btnRewind(btnRewind), .btnPlay(btnPlay), .btnPause(btnPause),
    .btnLive(btnLive), .btnBegin(btnBegin),
    .longHold(longHold), .atNewest(atNewest), .ctl(ctl),
    .ledPause(ledPause), .ledLive(ledLive), .ledPower(ledPower)
  );

  tsb_datapath #(
    .ADDR_W(ADDR_W), .SAMPLE_W(12), .WORD_W(16), .JUMP_LEN(JUMP_LEN)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inSample(inSample),
    .memRdata(memRdata), .memWe(memWe), .memWaddr(memWaddr),
    .memWdata(memWdata), .memRe(memRe), .memRaddr(memRaddr),
    .outSample(outSample), .outStb(outStb), .atNewest(atNewest)
  );
endmodule

// File: rtl/time_shift_buffer_chk.sv
module time_shift_buffer_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              inStb,
  input logic [ADDR_W-1:0] memWaddr,
  input logic              outStb,
  input logic              ledPause,
  input logic              ledLive,
  input logic              ledPower
);
  localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);

  // R1: each strobe advances the write address by one (modulo depth)
  p_waddr_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    inStb |=> memWaddr == $past(memWaddr) + ONE_A);

  // R1: no strobe, no movement of the write address
  p_waddr_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inStb |=> $stable(memWaddr));

  // R2: every playback pulse stems from a strobe two edges earlier
  p_out_after_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    outStb |-> $past(inStb, 2));

  // R3: a paused strobe never produces output
  p_silent_paused_r3: assert property (@(posedge clk) disable iff (!rstN)
    $past(ledPause, 2) |-> !outStb);

  // R11: pause and live indicators never light together
  p_led_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(ledPause && ledLive));

  // R11: power indicator lit once out of reset
  p_power_on_r11: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ledPower);
endmodule

bind time_shift_buffer time_shift_buffer_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .inStb(inStb), .memWaddr(memWaddr),
  .outStb(outStb), .ledPause(ledPause), .ledLive(ledLive),
  .ledPower(ledPower)
);

// File: tb/time_shift_buffer_tb_top.sv
`timescale 1ns/1ps
module time_shift_buffer_tb_top;
  localparam int ADDR_W = 6;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int JUMP   = 10;
  localparam int HOLD   = 40;

  // Op codes of the stimulus table
  localparam int OP_SAMP = 0, OP_PAUSE = 1, OP_PLAY = 2, OP_LIVE = 3,
                 OP_BEGIN = 4, OP_REWS = 5, OP_REWL = 6;
  localparam int NOPS = 22;
  localparam int OPS [NOPS] = '{
    OP_SAMP, OP_PAUSE, OP_SAMP, OP_PLAY, OP_SAMP, OP_REWS, OP_SAMP,
    OP_REWS, OP_REWS, OP_SAMP, OP_BEGIN, OP_SAMP, OP_LIVE, OP_SAMP,
    OP_SAMP, OP_BEGIN, OP_SAMP, OP_REWL, OP_SAMP, OP_REWL, OP_LIVE, OP_SAMP};
  localparam int ARGS [NOPS] = '{
    20, 0, 6, 0, 4, 0, 3,
    0, 0, 2, 0, 3, 0, 3,
    60, 0, 3, 5, 2, 70, 0, 2};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [11:0] inSample = '0;
  logic inStb = 1'b0;
  logic btnRewind = 1'b0, btnPlay = 1'b0, btnPause = 1'b0;
  logic btnLive = 1'b0, btnBegin = 1'b0;
  logic memWe, memRe, outStb, ledPause, ledLive, ledPower;
  logic [ADDR_W-1:0] memWaddr, memRaddr;
  logic [15:0] memWdata;
  logic [15:0] memRdata = '0;
  logic [11:0] outSample;
  logic [15:0] mem [DEPTH];

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  // Reference model state: sample serial numbers
  int total = 0;
  int nextIdx = -1;
  bit mPaused = 1'b0, mRev = 1'b0;

  always #2.5 clk = ~clk;

  time_shift_buffer #(.ADDR_W(ADDR_W), .JUMP_LEN(JUMP), .HOLD_CYCLES(HOLD)) dut_i (
    .clk(clk), .rstN(rstN), .inSample(inSample), .inStb(inStb),
    .btnRewind(btnRewind), .btnPlay(btnPlay), .btnPause(btnPause),
    .btnLive(btnLive), .btnBegin(btnBegin),
    .memWe(memWe), .memWaddr(memWaddr), .memWdata(memWdata),
    .memRe(memRe), .memRaddr(memRaddr), .memRdata(memRdata),
    .outSample(outSample), .outStb(outStb),
    .ledPause(ledPause), .ledLive(ledLive), .ledPower(ledPower));

  // Synchronous memory model, one cycle read latency
  always @(posedge clk) begin
    if (memWe) mem[memWaddr] <= memWdata;
    if (memRe) memRdata <= mem[memRaddr];
  end

  function automatic logic [11:0] sampleVal(int i);
    return 12'((i * 37 + 5) & 12'hFFF);
  endfunction

  function automatic int oldestIdx(int t);
    return (t > DEPTH) ? t - DEPTH : 0;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkLeds(string req);
    bit expLive;
    expLive = !mPaused && !mRev && (nextIdx == total - 1);
    check(ledLive == expLive, {req, " ledLive"}, int'(ledLive), int'(expLive));
    check(ledPause == (mPaused && !mRev), {req, " ledPause"}, int'(ledPause),
          int'(mPaused && !mRev));
  endtask

  // One sample strobe; optionally a pause edge landing in the same cycle (R10)
  task automatic sendSample(bit withPause);
    bit expEmit;
    int expVal;
    logic [11:0] v;
    v = sampleVal(total);
    expEmit = !mPaused || mRev;
    expVal  = (total == 0) ? 0 : int'(sampleVal(nextIdx));
    @(negedge clk);
    inSample = v; inStb = 1'b1;
    if (withPause) btnPause = 1'b1;
    #1;
    check(memWe && memWaddr == ADDR_W'(total % DEPTH), "R1 write address",
          int'(memWaddr), total % DEPTH);
    check(memWdata == {4'b0000, v}, "R1 write word", int'(memWdata), int'(v));
    @(negedge clk);
    inStb = 1'b0;
    @(negedge clk);
    check(outStb == expEmit, "R2/R3 output strobe", int'(outStb), int'(expEmit));
    if (expEmit)
      check(outSample == 12'(expVal), mRev ? "R6 reverse sample" : "R2 played sample",
            int'(outSample), expVal);
    total++;
    if (expEmit && !mRev) nextIdx++;
    else if (mRev) nextIdx = (nextIdx - 1 < oldestIdx(total)) ? oldestIdx(total) : nextIdx - 1;
    else if (nextIdx < oldestIdx(total)) nextIdx = oldestIdx(total);  // R4
    if (withPause) begin
      btnPause = 1'b0;
      mPaused = 1'b1;
      check(ledPause == 1'b1, "R10 deferred pause", int'(ledPause), 1);
    end
    @(negedge clk);
  endtask

  task automatic pulse(ref logic b);
    @(negedge clk); b = 1'b1;
    @(negedge clk); b = 1'b0;
    @(negedge clk);
  endtask

  task automatic modelRewind();
    if (total > 0)
      nextIdx = (nextIdx - JUMP < oldestIdx(total)) ? oldestIdx(total) : nextIdx - JUMP;
  endtask

  task automatic modelBegin();
    nextIdx = (total == 0) ? -1 : oldestIdx(total);
  endtask

  task automatic shortRewind();
    @(negedge clk); btnRewind = 1'b1;
    repeat (HOLD / 2) @(negedge clk);
    btnRewind = 1'b0;
    repeat (3) @(negedge clk);
    modelRewind();
    checkLeds("R5 short rewind");
  endtask

  task automatic longRewind(int n, bit tryPause);
    @(negedge clk); btnRewind = 1'b1;
    repeat (HOLD + 4) @(negedge clk);
    mRev = 1'b1;
    check(!ledLive && !ledPause, "R6 reverse leds off", int'(ledLive), 0);
    if (tryPause) pulse(btnPause);  // R9: ignored while reversing
    for (int k = 0; k < n; k++) sendSample(1'b0);
    @(negedge clk); btnRewind = 1'b0;
    repeat (3) @(negedge clk);
    mRev = 1'b0;
    checkLeds("R6 after release");
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R12: reset state
    check(outSample == 12'd0 && !outStb, "R12 output idle", int'(outSample), 0);
    check(ledLive == 1'b1, "R12 live at reset", int'(ledLive), 1);
    check(ledPause == 1'b0, "R12 unpaused", int'(ledPause), 0);
    rstN = 1'b1;
    @(negedge clk); @(negedge clk);
    check(ledPower == 1'b1, "R11 power led", int'(ledPower), 1);

    // Table walk: first strobe on an empty buffer plays zero (R2)
    for (int s = 0; s < NOPS; s++) begin
      case (OPS[s])
        OP_SAMP:  for (int k = 0; k < ARGS[s]; k++) sendSample(1'b0);
        OP_PAUSE: begin pulse(btnPause); mPaused = 1'b1; checkLeds("R3 pause"); end
        OP_PLAY:  begin pulse(btnPlay);  mPaused = 1'b0; checkLeds("R3 play"); end
        OP_LIVE:  begin pulse(btnLive); nextIdx = total - 1; mPaused = 1'b0;
                        checkLeds("R7 live"); end
        OP_BEGIN: begin pulse(btnBegin); modelBegin(); checkLeds("R8 begin"); end
        OP_REWS:  shortRewind();
        OP_REWL:  longRewind(ARGS[s], 1'b0);
        default:  ;
      endcase
    end

    // R4: pause outlasting the whole buffer, then resume at oldest
    pulse(btnPause); mPaused = 1'b1;
    for (int k = 0; k < DEPTH + 5; k++) sendSample(1'b0);
    pulse(btnPlay); mPaused = 1'b0;
    for (int k = 0; k < 3; k++) sendSample(1'b0);

    // R5: short rewind while paused keeps the pause
    pulse(btnPause); mPaused = 1'b1;
    shortRewind();
    pulse(btnPlay); mPaused = 1'b0;
    sendSample(1'b0);

    // R9: live beats pause in the same cycle
    @(negedge clk); btnLive = 1'b1; btnPause = 1'b1;
    @(negedge clk); btnLive = 1'b0; btnPause = 1'b0;
    @(negedge clk);
    nextIdx = total - 1; mPaused = 1'b0;
    checkLeds("R9 live over pause");
    // R9: begin beats play while paused; pause stays
    pulse(btnPause); mPaused = 1'b1;
    @(negedge clk); btnBegin = 1'b1; btnPlay = 1'b1;
    @(negedge clk); btnBegin = 1'b0; btnPlay = 1'b0;
    @(negedge clk);
    modelBegin();
    checkLeds("R9 begin over play");
    sendSample(1'b0);
    pulse(btnLive); nextIdx = total - 1; mPaused = 1'b0;

    // R9: pause pressed during reverse is ignored
    longRewind(4, 1'b1);
    sendSample(1'b0);

    // R10: pause edge landing on a strobe acts one cycle later
    sendSample(1'b1);
    sendSample(1'b0);
    pulse(btnPlay); mPaused = 1'b0;
    sendSample(1'b0);

    finished = 1'b1;
    summary();
  end
endmodule